// File: doc/BRIEF.md
# Counter-Based Thermal Threshold Monitor

This block watches one on-die temperature sensor. The sensor is a ring oscillator whose frequency rises with temperature. An upstream prescaler delivers the oscillator's edges as a small edge count per system clock. The monitor adds up those edges over a programmed number of reference ticks. It then compares the finished count against three programmable limits and turns the result into a thermal level from 0 (cold) to 3 (critical).

Each level drives a hardware request output, and each request has its own enable: level 1 asks for DVFS, level 2 asks for a divide-by-two clock throttle, and level 3 asks for an emergency thermal reset. An interrupt is raised when the level rises across an enabled limit, and also when the counter saturates. A small word-addressed register port gives access to the control word, the limits, the status and the last count. The status flags are cleared by writing one to them.

Top module: `therm_cnt_mon`

## Requirements
- R1: After reset, the control word reads 0, both limit words read with every limit at 0xFFFF, and status and count read 0. No measurement runs while the period field or the window field is zero, even when the stop bit is clear.
- R2: While control bit 0 (stop) is set, no measurement runs. The valid flag (status bit 9) and the level both return to 0 one cycle after stop is seen.
- R3: A measurement sums the oscillator edges over the first W reference ticks of each period. W is control bits 31:24, the period P is control bits 23:8, and the period lasts max(P,W) ticks. The count appears in count-register bits 31:16, and the valid flag sets on the clock edge that ends the window.
- R4: The level is the highest index i whose limit is at or below the count. Limit 1 sits in bits 15:0 of word 1, limit 2 in bits 31:16 of word 1, and limit 3 in bits 15:0 of word 2. The level is recomputed only at the end of a window. Status bits 2:0 show it.
- R5: dvfs_req is high when level ≥ 1 and control bit 3 is set. clkdiv_req is high when level ≥ 2 and bit 1 is set. therm_rst_req is high when level is 3 and bit 2 is set.
- R6: The interrupt flag (status bit 8, also the irq pin) sets when a window end raises the level across limit 1 with bit 3 set, across limit 2 with bit 5 set, or across limit 3 with bit 6 set. Several limits may be crossed in one step.
- R7: A window that lowers or keeps the level raises no interrupt.
- R8: A count that reaches 0xFFFF saturates there and is an overflow. The state field then reads 5 until cleared, the level is forced to 3, and the interrupt flag sets if control bit 4 is set.
- R9: Writing status (word 3) with bit 8 set clears the interrupt flag. Writing status with state field 5 clears the overflow state. A status write of 0 changes nothing.
- R10: Register words are: 0 control, 1 limits 1 and 2, 2 limit 3, 3 status, 4 count. All of them except count and status read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference clock pulse |
| osc_edges | input | 4 | Oscillator edges seen this cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt flag |
| dvfs_req | output | 1 | DVFS request (level 1) |
| clkdiv_req | output | 1 | Clock divide request (level 2) |
| therm_rst_req | output | 1 | Emergency thermal reset request (level 3) |

## Verification
The bench targets the count being exactly equal to a limit. A design that compared with a strict greater-than would report one level too low there. It checks that the first result lands on the exact edge that ends the window and that the next result waits for the full period. A design with an off-by-one timer would publish a tick early or late, or would re-measure without pausing. It also drives a level that falls while running, a jump from 0 straight to 3 with only the level-3 interrupt enabled, and a saturating count. Wrong designs there would interrupt on cooling, miss a multi-level crossing, or wrap the counter back to a cold value.

// File: rtl/tcm_pkg.sv
// Shared widths, register addresses and control word layout for the
// counter-based thermal monitor. Assumes a 32-bit register port.
package tcm_pkg;
    localparam int PER_W  = 16;
    localparam int WIN_W  = 8;
    localparam int CNT_W  = 16;
    localparam int EDGE_W = 4;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LIM12 = 3'd1;
    localparam logic [ADDR_W-1:0] A_LIM3  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT   = 3'd4;

    localparam logic [2:0] ST_OVF = 3'd5;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [PER_W-1:0] per;
        logic             rsv;
        logic             ie_rst;
        logic             ie_div;
        logic             ie_ovf;
        logic             en_dvfs;
        logic             en_rst;
        logic             en_div;
        logic             stop;
    } ctrl_t;
endpackage

// File: rtl/tcm_meas.sv
// Measurement engine: a reference-tick timer walks each period. During the
// first WIN ticks, the oscillator edges are summed into a saturating counter.
// Assumes win != 0 whenever run is high.
module tcm_meas #(
    parameter int PER_W  = tcm_pkg::PER_W,
    parameter int WIN_W  = tcm_pkg::WIN_W,
    parameter int CNT_W  = tcm_pkg::CNT_W,
    parameter int EDGE_W = tcm_pkg::EDGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ref_tick,
    input  logic [EDGE_W-1:0] edges,
    input  logic [PER_W-1:0]  per,
    input  logic [WIN_W-1:0]  win,
    output logic              done,
    output logic [CNT_W-1:0]  cnt,
    output logic              ovf
);
    localparam int TMR_W = (PER_W > WIN_W) ? PER_W : WIN_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [TMR_W-1:0] tmr, win_len, per_len;
    logic [CNT_W-1:0] acc, acc_nxt;
    logic [CNT_W:0]   sum;
    logic             in_win;

    // Derive window and period lengths in timer units and the saturating sum.
    always_comb begin
        win_len = TMR_W'(win);
        per_len = (TMR_W'(per) > win_len) ? TMR_W'(per) : win_len;
        in_win  = tmr < win_len;
        sum     = {1'b0, acc} + (CNT_W+1)'(edges);
        acc_nxt = (sum >= {1'b0, CNT_MAX}) ? CNT_MAX : sum[CNT_W-1:0];
        done    = run && ref_tick && in_win && (tmr == win_len - 1'b1);
        cnt     = acc_nxt;
        ovf     = (acc_nxt == CNT_MAX);
    end

    // Advance the period timer and accumulate edges inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tmr <= '0;
            acc <= '0;
        end else begin
            if (done)        acc <= '0;
            else if (in_win) acc <= acc_nxt;
            if (ref_tick)    tmr <= (tmr >= per_len - 1'b1) ? '0 : tmr + 1'b1;
        end
    end

    // R3: every finished window leaves the accumulator empty for the next one.
    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (acc == '0));
endmodule

// File: rtl/tcm_level.sv
// Level compare: picks the highest limit index whose limit the count meets.
// An overflowed count is treated as the hottest level.
module tcm_level #(
    parameter int CNT_W = tcm_pkg::CNT_W,
    parameter int NLIM  = 3
) (
    input  logic [CNT_W-1:0]           cnt,
    input  logic                       ovf,
    input  logic [NLIM-1:0][CNT_W-1:0] lims,
    output logic [$clog2(NLIM+1)-1:0]  lvl
);
    localparam int LVL_W = $clog2(NLIM+1);

    // Ascending scan so that a higher satisfied limit overrides a lower one.
    always_comb begin
        lvl = '0;
        for (int i = 0; i < NLIM; i++) begin
            if (cnt >= lims[i]) lvl = LVL_W'(i + 1);
        end
        if (ovf) lvl = LVL_W'(NLIM);
    end
endmodule

// File: rtl/tcm_regs.sv
// Register file and result state: control and limit registers, the published
// count, level, valid flag, sticky overflow and interrupt flag with
// write-one-to-clear. Assumes single-cycle writes and combinational reads.
module tcm_regs
    import tcm_pkg::*;
#(
    parameter int CNT_W = tcm_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              done,
    input  logic [CNT_W-1:0]  meas_cnt,
    input  logic              meas_ovf,
    input  logic [1:0]        new_lvl,
    output ctrl_t             ctrl,
    output logic [2:0][CNT_W-1:0] lims,
    output logic              run,
    output logic [1:0]        lvl_q,
    output logic              irq_q
);
    logic [CNT_W-1:0] cnt_q;
    logic             valid_q, ovf_q, irq_set, irq_clr, ovf_clr, up;
    logic [3:0]       ie_lvl;
    logic [2:0]       state;

    assign run = !ctrl.stop && (ctrl.per != '0) && (ctrl.win != '0);

    // Register writes for control and limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            lims <= '1;
        end else if (reg_we) begin
            case (reg_addr)
                A_CTRL:  ctrl <= ctrl_t'(reg_wdata);
                A_LIM12: begin
                    lims[0] <= reg_wdata[CNT_W-1:0];
                    lims[1] <= reg_wdata[16 +: CNT_W];
                end
                A_LIM3:  lims[2] <= reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Decide whether this window end crosses an enabled limit upward.
    always_comb begin
        ie_lvl = {ctrl.ie_rst, ctrl.ie_div, ctrl.en_dvfs, 1'b0};
        up = 1'b0;
        for (int l = 1; l < 4; l++) begin
            if (lvl_q < 2'(l) && new_lvl >= 2'(l) && ie_lvl[l]) up = 1'b1;
        end
        irq_set = done && (up || (meas_ovf && ctrl.ie_ovf));
        irq_clr = reg_we && (reg_addr == A_STAT) && reg_wdata[8];
        ovf_clr = reg_we && (reg_addr == A_STAT) && (reg_wdata[2:0] == ST_OVF);
        state   = ovf_q ? ST_OVF : {1'b0, lvl_q};
    end

    // Publish results at each window end; clear them when measurement halts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            lvl_q   <= '0;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (!run) begin
                valid_q <= 1'b0;
                lvl_q   <= '0;
            end else if (done) begin
                valid_q <= 1'b1;
                lvl_q   <= new_lvl;
                cnt_q   <= meas_cnt;
            end
            ovf_q <= (done && meas_ovf) || (ovf_q && !ovf_clr);
            irq_q <= irq_set || (irq_q && !irq_clr);
        end
    end

    // Combinational read mux.
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = ctrl;
            A_LIM12: reg_rdata = {lims[1], lims[0]};
            A_LIM3:  reg_rdata = {16'h0, lims[2]};
            A_STAT:  reg_rdata = {22'h0, valid_q, irq_q, 5'h0, state};
            A_CNT:   reg_rdata = {cnt_q, 16'h0};
            default: reg_rdata = '0;
        endcase
    end

    // R4: the level moves only at a window end or when measurement halts.
    assert_lvl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> $past(done || !run));
    // R6: the interrupt flag rises only as a result of a window end.
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(done));
    // R7: a falling, non-overflowing result never raises the flag.
    assert_no_fall_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && run && new_lvl < lvl_q && !meas_ovf && !irq_q) |=> !irq_q);
    // R8: a saturated window always leaves the overflow state set.
    assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && meas_ovf) |=> ovf_q);
    // R2: valid drops only because measurement stopped.
    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_q) |-> $past(!run));
endmodule

// File: rtl/therm_cnt_mon.sv
// Top of the counter-based thermal monitor: measurement engine, level compare
// and register file, plus the enable-gated hardware request outputs.
module therm_cnt_mon
    import tcm_pkg::*;
#(
    parameter int EDGES_W = tcm_pkg::EDGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic [EDGES_W-1:0] osc_edges,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq,
    output logic               dvfs_req,
    output logic               clkdiv_req,
    output logic               therm_rst_req
);
    ctrl_t                   ctrl;
    logic [2:0][CNT_W-1:0]   lims;
    logic                    run, done, meas_ovf;
    logic [CNT_W-1:0]        meas_cnt;
    logic [1:0]              new_lvl, lvl_q;

    tcm_meas #(.PER_W(PER_W), .WIN_W(WIN_W), .CNT_W(CNT_W), .EDGE_W(EDGES_W)) u_meas (
        .clk(clk), .rst_n(rst_n), .run(run), .ref_tick(ref_tick),
        .edges(osc_edges), .per(ctrl.per), .win(ctrl.win),
        .done(done), .cnt(meas_cnt), .ovf(meas_ovf)
    );

    tcm_level #(.CNT_W(CNT_W), .NLIM(3)) u_level (
        .cnt(meas_cnt), .ovf(meas_ovf), .lims(lims), .lvl(new_lvl)
    );

    tcm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
        .meas_cnt(meas_cnt), .meas_ovf(meas_ovf), .new_lvl(new_lvl),
        .ctrl(ctrl), .lims(lims), .run(run), .lvl_q(lvl_q), .irq_q(irq)
    );

    // Gate each hardware action by its level and its enable bit.
    always_comb begin
        dvfs_req      = ctrl.en_dvfs && (lvl_q >= 2'd1);
        clkdiv_req    = ctrl.en_div  && (lvl_q >= 2'd2);
        therm_rst_req = ctrl.en_rst  && (lvl_q == 2'd3);
    end

    // R5: the reset request never appears without its enable.
    assert_rst_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        therm_rst_req |-> (ctrl.en_rst && run));
endmodule

// File: tb/sim_therm_cnt_mon.sv
module sim_therm_cnt_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic [3:0]  osc_edges = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, dvfs_req, clkdiv_req, therm_rst_req;
    int checks = 0;
    int errors = 0;
    bit slow_ref = 1'b0;
    int div_cnt = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    therm_cnt_mon u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .osc_edges(osc_edges),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .dvfs_req(dvfs_req),
        .clkdiv_req(clkdiv_req), .therm_rst_req(therm_rst_req)
    );

    // Reference tick: every cycle, or one tick in 64 cycles in slow mode.
    always @(negedge clk) begin
        if (slow_ref) begin
            ref_tick <= (div_cnt == 63);
            div_cnt  <= (div_cnt == 63) ? 0 : div_cnt + 1;
        end else begin
            ref_tick <= 1'b1;
        end
    end

    typedef struct packed {
        logic [7:0]  n;
        logic [3:0]  e;
        logic [15:0] l1, l2, l3;
        logic [7:0]  en;
        logic [2:0]  st;
        logic        xirq, xdvfs, xdiv, xrst;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{8'd10,  4'd1,  16'd20,   16'd30,   16'd40,   8'h7E, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'd10,  4'd2,  16'd20,   16'd30,   16'd40,   8'h7E, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{8'd10,  4'd3,  16'd20,   16'd30,   16'd40,   8'h7E, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0},
        '{8'd10,  4'd4,  16'd20,   16'd30,   16'd40,   8'h7E, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1},
        '{8'd10,  4'd4,  16'd20,   16'd30,   16'd40,   8'h00, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'd10,  4'd3,  16'd20,   16'd30,   16'd40,   8'h22, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0},
        '{8'd10,  4'd2,  16'd20,   16'd30,   16'd40,   8'h60, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'd5,   4'd15, 16'd20,   16'd30,   16'd40,   8'h40, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0},
        '{8'd12,  4'd0,  16'd0,    16'd5,    16'd6,    8'h08, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{8'd255, 4'd15, 16'd3825, 16'd3826, 16'd4000, 8'h04, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R10: reset values
        rd(3'd0, d); chk("R1 ctrl reset", d, 32'h0);
        rd(3'd1, d); chk("R1 limits 1/2 reset", d, 32'hFFFF_FFFF);
        rd(3'd2, d); chk("R1 limit 3 reset", d, 32'h0000_FFFF);
        rd(3'd3, d); chk("R1 status reset", d, 32'h0);
        rd(3'd4, d); chk("R1 count reset", d, 32'h0);
        chk("R1 outputs reset", {irq, dvfs_req, clkdiv_req, therm_rst_req}, 4'h0);
        // R1: enabled but unprogrammed, no measurement
        osc_edges = 4'd15;
        repeat (40) @(negedge clk);
        rd(3'd3, d); chk("R1 no measurement with zero period/window", d, 32'h0);

        // R3: first result timing and period spacing
        wr(3'd0, {8'd6, 16'd20, 8'h00});
        osc_edges = 4'd1;
        wr(3'd0, {8'd6, 16'd20, 8'h00});
        wr(3'd3, 32'h105);
        wr(3'd0, 32'h1);
        wr(3'd0, {8'd6, 16'd20, 8'h00});
        repeat (5) @(negedge clk);
        rd(3'd3, d); chk("R3 valid not yet set before window end", {31'h0, d[9]}, 32'h0);
        @(negedge clk);
        rd(3'd3, d); chk("R3 valid set at window end", {31'h0, d[9]}, 32'h1);
        rd(3'd4, d); chk("R3 count of first window", d, {16'd6, 16'h0});
        osc_edges = 4'd2;
        repeat (19) @(negedge clk);
        rd(3'd4, d); chk("R3 period not over yet", d, {16'd6, 16'h0});
        @(negedge clk);
        rd(3'd4, d); chk("R3 second window after full period", d, {16'd12, 16'h0});

        // Vector table: R4 levels, R5 requests, R6 interrupts
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, 32'h1);
            wr(3'd1, {VEC[i].l2, VEC[i].l1});
            wr(3'd2, {16'h0, VEC[i].l3});
            wr(3'd3, 32'h105);
            osc_edges = VEC[i].e;
            wr(3'd0, {VEC[i].n, 8'h0, VEC[i].n, VEC[i].en});
            repeat (int'(VEC[i].n) + 2) @(negedge clk);
            rd(3'd3, d);
            chk($sformatf("R4 state vec %0d", i), {29'h0, d[2:0]}, {29'h0, VEC[i].st});
            chk($sformatf("R6 irq vec %0d", i), {31'h0, irq}, {31'h0, VEC[i].xirq});
            chk($sformatf("R5 requests vec %0d", i), {29'h0, dvfs_req, clkdiv_req, therm_rst_req},
                {29'h0, VEC[i].xdvfs, VEC[i].xdiv, VEC[i].xrst});
            rd(3'd4, d);
            chk($sformatf("R3 count vec %0d", i), d, {16'(VEC[i].n * VEC[i].e), 16'h0});
        end

        // R2: stop clears valid and level
        wr(3'd0, {8'd255, 8'h0, 8'd255, 8'h05});
        repeat (3) @(negedge clk);
        rd(3'd3, d); chk("R2 stop clears valid and level", d, 32'h0);

        // R7 / R9: falling level and write-one-to-clear
        wr(3'd1, {16'd30, 16'd20});
        wr(3'd2, 32'd40);
        wr(3'd3, 32'h105);
        osc_edges = 4'd3;
        wr(3'd0, {8'd10, 8'h0, 8'd10, 8'h7E});
        repeat (12) @(negedge clk);
        chk("R6 irq on rise to level 2", {31'h0, irq}, 32'h1);
        wr(3'd3, 32'h0);
        chk("R9 status write of zero ignored", {31'h0, irq}, 32'h1);
        wr(3'd3, 32'h100);
        chk("R9 bit 8 clears irq", {31'h0, irq}, 32'h0);
        wr(3'd1, {16'd200, 16'd100});
        wr(3'd2, 32'd300);
        repeat (25) @(negedge clk);
        rd(3'd3, d); chk("R7 level fell without irq", d, 32'h200);
        chk("R7 irq pin low after fall", {31'h0, irq}, 32'h0);

        // R8: overflow with slow reference ticks
        wr(3'd0, 32'h1);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF);
        wr(3'd3, 32'h105);
        osc_edges = 4'd15;
        slow_ref = 1'b1;
        wr(3'd0, {8'd255, 8'h0, 8'd255, 8'h14});
        repeat (17000) @(negedge clk);
        rd(3'd3, d); chk("R8 overflow state with irq and valid", d, 32'h305);
        rd(3'd4, d); chk("R8 count saturates at 0xFFFF", d, 32'hFFFF_0000);
        chk("R8 overflow forces level 3 reset request", {31'h0, therm_rst_req}, 32'h1);
        wr(3'd3, 32'h105);
        rd(3'd3, d); chk("R9 clear of overflow and irq", d, 32'h203);
        finish_run();
    end
endmodule